// File: doc/BRIEF.md
# Oscillator Frequency Window Health Monitor

This block judges each finished frequency measurement against a programmable window and reports the result as a small status byte. The upper byte of the latched 16-bit count is compared with an 8-bit lower bound and an 8-bit upper bound. The block raises one of four flags: too slow, too fast, stuck (the count is zero), or healthy. The flags change only when a measurement-complete strobe arrives while checking is enabled. Between strobes they hold the last verdict.

Beside the window check, the block keeps two sticky fault records with one bit per oscillator: one for stuck results and one for too-slow results. A bit is set for whichever oscillator is selected at the strobe that reports the fault, and it stays set until a dedicated clear pulse. This lets a host sweep all oscillators and later read which ones ever misbehaved, without polling after every gate. Counting, oscillator control and the register interface sit outside this block.

Top module: `freq_health_mon`

## Requirements
- R1: A synchronous active-high reset clears status bits 3:0 and both history vectors to zero in the cycle after the reset edge.
- R2: A qualified strobe with a count of zero sets the stuck flag (status bit 2) and also the below flag (status bit 0), and clears ok (status bit 3).
- R3: A qualified strobe whose count upper byte (count bits 15:8) is strictly less than the lower bound sets the below flag (status bit 0).
- R4: A qualified strobe whose count upper byte is strictly greater than the upper bound sets the above flag (status bit 1). An upper byte equal to either bound sets neither flag.
- R5: The ok flag (status bit 3) is set exactly when below, above and stuck are all clear after a qualified strobe.
- R6: Status bits 3:0 change only on a clock edge where the strobe and the enable are both high, and take effect in the next cycle. At any other time they hold their value.
- R7: Status bit 4 follows the random-byte-valid input in the same cycle. Status bits 7:5 are always zero.
- R8: A qualified stuck result sets the stuck-history bit whose index equals the oscillator select. Bits already set stay set.
- R9: A qualified below result (including a stuck one) sets the below-history bit whose index equals the oscillator select. Bits already set stay set.
- R10: Select codes 5, 6 and 7 change no history bit. The status flags still update.
- R11: The clear pulse zeroes both history vectors in the next cycle and wins over a fault reported in the same cycle. It does not touch the status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| count_i | input | 16 | Latched measurement count |
| done_i | input | 1 | Measurement-complete strobe, one cycle |
| sel_i | input | 3 | Currently selected oscillator |
| enable_i | input | 1 | Health checking enable |
| lo_bound_i | input | 8 | Lower bound for the count upper byte |
| hi_bound_i | input | 8 | Upper bound for the count upper byte |
| clear_i | input | 1 | Self-clearing history clear pulse |
| rng_valid_i | input | 1 | Random byte valid, shown as status bit 4 |
| status_o | output | 8 | Status byte: 0 below, 1 above, 2 stuck, 3 ok, 4 random valid |
| hist_stuck_o | output | 5 | Sticky per-oscillator stuck history |
| hist_below_o | output | 5 | Sticky per-oscillator below-bound history |

## Verification
The assertions assume that the strobe, the select and the count are stable over the clock edge that qualifies a measurement, and that the bounds are not changed in the same cycle as a strobe. The stimulus drives every input on the falling edge and holds it through the next rising edge. It sets the bounds in cycles with no strobe, and it raises the clear pulse for single cycles only, sometimes together with a fault so that the priority case is covered. Select codes above the oscillator count are driven on purpose, to show that the history ignores them.

// File: rtl/freq_health_pkg.sv
package freq_health_pkg;

    localparam int STAT_BELOW = 0;
    localparam int STAT_ABOVE = 1;
    localparam int STAT_STUCK = 2;
    localparam int STAT_OK    = 3;
    localparam int STAT_RNG   = 4;

    typedef struct packed {
        logic ok;
        logic stuck;
        logic above;
        logic below;
    } health_flags_t;

    function automatic logic [7:0] pack_status(input health_flags_t f, input logic rng);
        logic [7:0] s;
        s = '0;
        s[STAT_BELOW] = f.below;
        s[STAT_ABOVE] = f.above;
        s[STAT_STUCK] = f.stuck;
        s[STAT_OK]    = f.ok;
        s[STAT_RNG]   = rng;
        return s;
    endfunction

endpackage

// File: rtl/fhm_window_cmp.sv
module fhm_window_cmp
    import freq_health_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int BOUND_W = 8
) (
    input  logic [CNT_W-1:0]   count,
    input  logic [BOUND_W-1:0] lo_bound,
    input  logic [BOUND_W-1:0] hi_bound,
    output health_flags_t      flags
);
    logic [BOUND_W-1:0] top_byte;
    logic               zero_cnt;

    assign top_byte = count[CNT_W-1 -: BOUND_W];
    assign zero_cnt = (count == '0);

    always_comb begin
        flags.stuck = zero_cnt;
        flags.below = zero_cnt || (top_byte < lo_bound);
        flags.above = top_byte > hi_bound;
        flags.ok    = !(flags.stuck || flags.below || flags.above);
    end
endmodule

// File: rtl/fhm_flag_reg.sv
module fhm_flag_reg
    import freq_health_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  health_flags_t flags_d,
    output health_flags_t flags_q
);
    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (load)
            flags_q <= flags_d;
    end
endmodule

// File: rtl/fhm_history.sv
module fhm_history #(
    parameter int NUM_OSC = 5,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               mark_stuck,
    input  logic               mark_below,
    input  logic [SEL_W-1:0]   sel,
    output logic [NUM_OSC-1:0] stuck_hist,
    output logic [NUM_OSC-1:0] below_hist
);
    for (genvar i = 0; i < NUM_OSC; i++) begin : g_osc
        logic hit;
        logic stuck_q;
        logic below_q;

        assign hit = (sel == SEL_W'(i));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                stuck_q <= 1'b0;
                below_q <= 1'b0;
            end else if (hit) begin
                if (mark_stuck) stuck_q <= 1'b1;
                if (mark_below) below_q <= 1'b1;
            end
        end

        assign stuck_hist[i] = stuck_q;
        assign below_hist[i] = below_q;
    end
endmodule

// File: rtl/freq_health_mon.sv
module freq_health_mon
    import freq_health_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BOUND_W  = 8,
    parameter int NUM_OSC  = 5,
    parameter int SEL_W    = 3,
    parameter int STATUS_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CNT_W-1:0]    count_i,
    input  logic                done_i,
    input  logic [SEL_W-1:0]    sel_i,
    input  logic                enable_i,
    input  logic [BOUND_W-1:0]  lo_bound_i,
    input  logic [BOUND_W-1:0]  hi_bound_i,
    input  logic                clear_i,
    input  logic                rng_valid_i,
    output logic [STATUS_W-1:0] status_o,
    output logic [NUM_OSC-1:0]  hist_stuck_o,
    output logic [NUM_OSC-1:0]  hist_below_o
);
    health_flags_t flags_now;
    health_flags_t flags_held;
    logic          qualified;
    logic [7:0]    status_full;

    assign qualified = done_i && enable_i;

    fhm_window_cmp #(.CNT_W(CNT_W), .BOUND_W(BOUND_W)) u_cmp (
        .count    (count_i),
        .lo_bound (lo_bound_i),
        .hi_bound (hi_bound_i),
        .flags    (flags_now)
    );

    fhm_flag_reg u_flags (
        .clk     (clk),
        .rst     (rst),
        .load    (qualified),
        .flags_d (flags_now),
        .flags_q (flags_held)
    );

    fhm_history #(.NUM_OSC(NUM_OSC), .SEL_W(SEL_W)) u_hist (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear_i),
        .mark_stuck (qualified && flags_now.stuck),
        .mark_below (qualified && flags_now.below),
        .sel        (sel_i),
        .stuck_hist (hist_stuck_o),
        .below_hist (hist_below_o)
    );

    assign status_full = pack_status(flags_held, rng_valid_i);
    assign status_o    = STATUS_W'(status_full);
endmodule

// File: rtl/fhm_checker.sv
module fhm_checker #(
    parameter int CNT_W    = 16,
    parameter int NUM_OSC  = 5,
    parameter int SEL_W    = 3,
    parameter int STATUS_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [CNT_W-1:0]    count_i,
    input logic                done_i,
    input logic [SEL_W-1:0]    sel_i,
    input logic                enable_i,
    input logic                clear_i,
    input logic [STATUS_W-1:0] status_o,
    input logic [NUM_OSC-1:0]  hist_stuck_o,
    input logic [NUM_OSC-1:0]  hist_below_o
);
    AST_OK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        status_o[3] |-> (status_o[2:0] == 3'b000)); // R5

    AST_STUCK_IS_BELOW: assert property (@(posedge clk) disable iff (rst)
        status_o[2] |-> status_o[0]); // R2

    AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(done_i && enable_i) |=> $stable(status_o[3:0])); // R6

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (hist_stuck_o == '0 && hist_below_o == '0)); // R11

    AST_STUCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((hist_stuck_o & $past(hist_stuck_o)) == $past(hist_stuck_o))); // R8

    AST_BELOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((hist_below_o & $past(hist_below_o)) == $past(hist_below_o))); // R9

    AST_HIGH_SEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (sel_i >= SEL_W'(NUM_OSC) && !clear_i) |=>
            ($stable(hist_stuck_o) && $stable(hist_below_o))); // R10

    AST_STUCK_RECORDED: assert property (@(posedge clk) disable iff (rst)
        (done_i && enable_i && count_i == '0 && sel_i < SEL_W'(NUM_OSC) && !clear_i) |=>
            (((hist_stuck_o >> $past(sel_i)) & NUM_OSC'(1)) != '0)); // R8
endmodule

bind freq_health_mon fhm_checker #(
    .CNT_W(CNT_W), .NUM_OSC(NUM_OSC), .SEL_W(SEL_W), .STATUS_W(STATUS_W)
) u_chk (
    .clk(clk), .rst(rst), .count_i(count_i), .done_i(done_i), .sel_i(sel_i),
    .enable_i(enable_i), .clear_i(clear_i), .status_o(status_o),
    .hist_stuck_o(hist_stuck_o), .hist_below_o(hist_below_o)
);

// File: tb/freq_health_mon_bench.sv
module freq_health_mon_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] count_i = '0;
    logic        done_i = 1'b0;
    logic [2:0]  sel_i = '0;
    logic        enable_i = 1'b0;
    logic [7:0]  lo_bound_i = '0;
    logic [7:0]  hi_bound_i = '0;
    logic        clear_i = 1'b0;
    logic        rng_valid_i = 1'b0;
    logic [7:0]  status_o;
    logic [4:0]  hist_stuck_o;
    logic [4:0]  hist_below_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    int m_below = 0, m_above = 0, m_stuck = 0, m_ok = 0;
    int m_hs = 0, m_hb = 0;

    always #4 clk = ~clk;

    freq_health_mon u_freq_health_mon (
        .clk(clk), .rst(rst), .count_i(count_i), .done_i(done_i), .sel_i(sel_i),
        .enable_i(enable_i), .lo_bound_i(lo_bound_i), .hi_bound_i(hi_bound_i),
        .clear_i(clear_i), .rng_valid_i(rng_valid_i), .status_o(status_o),
        .hist_stuck_o(hist_stuck_o), .hist_below_o(hist_below_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        int top;
        bit b, a, s, q;
        if (rst) begin
            m_below = 0; m_above = 0; m_stuck = 0; m_ok = 0; m_hs = 0; m_hb = 0;
            return;
        end
        top = int'(count_i) / 256;
        s = (count_i == 0);
        b = s || (top < int'(lo_bound_i));
        a = top > int'(hi_bound_i);
        q = !(s || b || a);
        if (clear_i) begin
            m_hs = 0; m_hb = 0;
        end else if (done_i && enable_i && sel_i < 5) begin
            if (s) m_hs = m_hs | (1 << sel_i);
            if (b) m_hb = m_hb | (1 << sel_i);
        end
        if (done_i && enable_i) begin
            m_below = b; m_above = a; m_stuck = s; m_ok = q;
        end
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check({tag, " status"}, int'(status_o),
              (int'(rng_valid_i) << 4) | (m_ok << 3) | (m_stuck << 2) | (m_above << 1) | m_below);
        check({tag, " stuck history"}, int'(hist_stuck_o), m_hs);
        check({tag, " below history"}, int'(hist_below_o), m_hb);
    endtask

    task automatic meas(input logic [15:0] c, input logic [2:0] s, input string tag);
        count_i = c; sel_i = s; done_i = 1'b1;
        step(tag);
        done_i = 1'b0;
        step({tag, " hold"});
    endtask

    initial begin
        @(negedge clk);
        rst = 1'b1;
        step("R1 reset");
        step("R1 reset");
        check("R1 status zero", int'(status_o), 0);
        check("R1 histories zero", int'(hist_stuck_o) | int'(hist_below_o), 0);
        rst = 1'b0;
        step("R1 after reset");

        lo_bound_i = 8'h40; hi_bound_i = 8'h60; enable_i = 1'b1;
        step("R6 bounds set");
        meas(16'h5000, 3'd0, "R5 inside window");
        check("R5 ok bit", int'(status_o[3]), 1);
        meas(16'h3FFF, 3'd1, "R3 below bound");
        check("R3 below bit", int'(status_o[0]), 1);
        check("R9 below history bit1", int'(hist_below_o[1]), 1);
        meas(16'h6100, 3'd0, "R4 above bound");
        check("R4 above bit", int'(status_o[1]), 1);
        meas(16'h60FF, 3'd0, "R4 equal upper");
        meas(16'h4000, 3'd0, "R4 equal lower");
        check("R4 equal bounds ok", int'(status_o[3:0]), 8);
        meas(16'h0000, 3'd2, "R2 stuck");
        check("R2 stuck plus below", int'(status_o[3:0]), 5);
        check("R8 stuck history bit2", int'(hist_stuck_o[2]), 1);

        enable_i = 1'b0;
        meas(16'h7000, 3'd0, "R6 disabled strobe");
        enable_i = 1'b1;
        count_i = 16'h7000;
        step("R6 no strobe");
        meas(16'h5000, 3'd2, "R8 sticky after ok");
        check("R8 bit2 kept", int'(hist_stuck_o[2]), 1);

        for (int s = 5; s < 8; s++) meas(16'h0000, 3'(s), "R10 high select");
        check("R10 flags still update", int'(status_o[2]), 1);

        for (int s = 0; s < 5; s++) meas(16'h0100, 3'(s), "R9 sweep below");
        count_i = 16'h0000; sel_i = 3'd3; done_i = 1'b1; clear_i = 1'b1;
        step("R11 clear with fault");
        done_i = 1'b0; clear_i = 1'b0;
        check("R11 cleared", int'(hist_stuck_o) | int'(hist_below_o), 0);
        check("R11 flags updated", int'(status_o[2]), 1);
        step("R11 after");

        rng_valid_i = 1'b1;
        #1;
        check("R7 rng same cycle", int'(status_o[4]), 1);
        check("R7 upper bits zero", int'(status_o[7:5]), 0);
        step("R7 rng high");
        rng_valid_i = 1'b0;
        step("R7 rng low");

        rst = 1'b1;
        step("R1 second reset");
        rst = 1'b0;
        step("R1 post");

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule